// File: doc/BRIEF.md
# Two-Channel Mappable Interrupt Controller

This block gathers a bank of external interrupt lines and turns them into two active-low processor requests: a fast channel and a normal channel. Between the physical lines and the outputs sit 24 logical interrupts. Each logical interrupt has its own control word. The word chooses which physical line the interrupt watches, whether it senses a level or an edge, which polarity counts as active, and whether the interrupt may reach its channel. Logical interrupts 0 to 19 feed the normal channel and 20 to 23 feed the fast channel. The two channels are built the same way and do not interact. At the processor the fast channel outranks the normal one.

Every physical line passes through a two-flop synchroniser before it is sensed. An edge event is held in a per-interrupt latch until software clears it. A level interrupt is pending for as long as its input is active. The pending vector is visible at all times, whether or not an interrupt is enabled. Each channel output is a registered NOR over the enabled pending interrupts of that channel.

Top module: `irqmap_top`

## Requirements
- R1: While reset is held (rst_ni low at a clock edge), and after it is released, both outputs read 1, every control word is zero and pend_o is all zero as long as ext_i[0] is 0.
- R2: A write with cfg_we_i=1 loads cfg_wdata_i into the control word of logical interrupt cfg_idx_i at that clock edge. The layout is bits [3:0] = physical source index, bit 4 = edge mode (1) or level mode (0), bit 5 = invert (1 = active low or falling edge), bit 6 = enable.
- R3: In level mode, pend_o[i] equals the selected input XOR invert. A change on ext_i shows on pend_o after the second rising clock edge.
- R4: In edge mode, an active transition of the selected input (rising edge, or falling edge when invert=1) sets pend_o[i] after the third rising clock edge. The bit then stays set after the input returns. The opposite transition sets nothing.
- R5: A cycle with clr_we_i=1 clears, at that edge, each edge-mode pending bit whose clr_mask_i bit is 1. Bits with a 0 in the mask keep their value.
- R6: A control-word write to an entry clears that entry's edge latch.
- R7: An entry whose enable bit is 0 still shows its pending bit on pend_o but never pulls its channel output low.
- R8: irq_n_o is registered. One edge after any enabled pending bit among entries 0..19 is seen, irq_n_o goes to 0. It returns to 1 one edge after none remain.
- R9: fiq_n_o follows entries 20..23 the same way as R8. Entries 20..23 never affect irq_n_o, and entries 0..19 never affect fiq_n_o.
- R10: Several entries may watch the same physical input. Rewriting an entry's source index redirects that entry alone.
- R11: A control-word write with cfg_idx_i of 24 or above changes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| ext_i | input | 16 | Asynchronous physical interrupt lines |
| cfg_we_i | input | 1 | Control-word write strobe |
| cfg_idx_i | input | 5 | Logical interrupt selected for the write |
| cfg_wdata_i | input | 7 | Control word: source, edge, invert, enable |
| clr_we_i | input | 1 | Write-one-to-clear strobe for edge latches |
| clr_mask_i | input | 24 | Per-entry clear mask |
| pend_o | output | 24 | Pending status of every logical interrupt |
| irq_n_o | output | 1 | Normal-channel request, active low |
| fiq_n_o | output | 1 | Fast-channel request, active low |

## Verification
The stimulus is a series of patterns, each chosen to separate two behaviours:
- A held high level separates level sensing from latching.
- A one-cycle pulse, followed by the line falling back, separates a held edge latch from a level that follows the input.
- A rise and a fall on a line watched by both a rising and a falling entry separate the two polarities.
- Clears with partial masks, and a control-word rewrite, separate clearing only the chosen latches from clearing them all.
- A disabled entry, then entries placed on the fast range, separate masking from routing to the wrong channel.
- Two entries on one input, with one of them then remapped, show that remapping is per entry.
- Out-of-range writes show that indices above 23 have no effect.

// File: rtl/irqmap_pkg.sv
// irqmap_pkg: types shared by the interrupt mapper.
// Assumes the control word is laid out as {enable, invert, edge, source}.
package irqmap_pkg;

    // Sensing mode held beside the source index in each control word.
    typedef struct packed {
        logic en;       // entry may drive its channel
        logic inv;      // active low level / falling edge
        logic edge_md;  // 1: edge latched, 0: level
    } cfg_mode_t;

    localparam int MODE_W = $bits(cfg_mode_t);

endpackage

// File: rtl/irqmap_sync.sv
// irqmap_sync: two-flop synchroniser per physical line, plus one extra
// stage kept so that edges can be detected downstream.
// Assumes ext_i is fully asynchronous to clk_i.
module irqmap_sync #(
    parameter int N_EXT = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [N_EXT-1:0] ext_i,
    output logic [N_EXT-1:0] sync_o,
    output logic [N_EXT-1:0] prev_o
);

    logic [N_EXT-1:0] meta_q;
    logic [N_EXT-1:0] sync_q;
    logic [N_EXT-1:0] prev_q;

    // Capture, resolve and delay every line once per clock.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= ext_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign sync_o = sync_q;
    assign prev_o = prev_q;

endmodule

// File: rtl/irqmap_entry.sv
// irqmap_entry: one logical interrupt. It holds the control word, selects
// its physical source, senses a level or an edge, and keeps the edge latch.
// Assumes the sync and prev inputs come from irqmap_sync.
// A latch set on the same edge as a clear stays set.
module irqmap_entry
    import irqmap_pkg::*;
#(
    parameter int N_EXT = 16,
    parameter int SRC_W = 4
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    wr_i,
    input  logic [SRC_W+MODE_W-1:0] wdata_i,
    input  logic                    clr_i,
    input  logic [N_EXT-1:0]        sync_i,
    input  logic [N_EXT-1:0]        prev_i,
    output logic                    pend_o,
    output logic                    en_o,
    output logic                    edge_o
);

    logic [SRC_W-1:0] src_q;
    cfg_mode_t        mode_q;
    logic             latch_q;
    logic             cur_act;
    logic             old_act;
    logic             hit;

    // Control word register, loaded on a write to this entry.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            src_q  <= '0;
            mode_q <= '0;
        end else if (wr_i) begin
            src_q  <= wdata_i[SRC_W-1:0];
            mode_q <= cfg_mode_t'(wdata_i[SRC_W +: MODE_W]);
        end
    end

    // Polarity-adjusted view of the selected line, now and one clock earlier.
    always_comb begin
        cur_act = sync_i[src_q] ^ mode_q.inv;
        old_act = prev_i[src_q] ^ mode_q.inv;
        hit     = cur_act & ~old_act;
    end

    // Edge latch: cleared by reset or reconfiguration; a new edge beats a clear.
    always_ff @(posedge clk_i) begin
        if (!rst_ni || wr_i) begin
            latch_q <= 1'b0;
        end else if (mode_q.edge_md && hit) begin
            latch_q <= 1'b1;
        end else if (clr_i) begin
            latch_q <= 1'b0;
        end
    end

    assign pend_o = mode_q.edge_md ? latch_q : cur_act;
    assign en_o   = mode_q.en;
    assign edge_o = mode_q.edge_md;

endmodule

// File: rtl/irqmap_chan.sv
// irqmap_chan: one output channel. It drives a registered, active-low
// request while any enabled pending entry of the channel remains.
// Assumes pend_i and en_i are synchronous to clk_i.
module irqmap_chan #(
    parameter int N = 4
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] pend_i,
    input  logic [N-1:0] en_i,
    output logic         req_n_o
);

    logic req_n_q;

    // Register the NOR of enabled pending entries.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            req_n_q <= 1'b1;
        end else begin
            req_n_q <= ~|(pend_i & en_i);
        end
    end

    assign req_n_o = req_n_q;

endmodule

// File: rtl/irqmap_top.sv
// irqmap_top: maps N_EXT physical lines onto N_NORM + N_FAST logical
// interrupts, which feed two active-low channels.
// Assumes a single clock and a synchronous active-low reset.
// Entries 0..N_NORM-1 are normal; the rest are fast.
module irqmap_top
    import irqmap_pkg::*;
#(
    parameter int N_EXT  = 16,
    parameter int N_NORM = 20,
    parameter int N_FAST = 4,
    localparam int N_LOG = N_NORM + N_FAST,
    localparam int SRC_W = $clog2(N_EXT),
    localparam int IDX_W = $clog2(N_LOG),
    localparam int CTL_W = SRC_W + MODE_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [N_EXT-1:0] ext_i,
    input  logic             cfg_we_i,
    input  logic [IDX_W-1:0] cfg_idx_i,
    input  logic [CTL_W-1:0] cfg_wdata_i,
    input  logic             clr_we_i,
    input  logic [N_LOG-1:0] clr_mask_i,
    output logic [N_LOG-1:0] pend_o,
    output logic             irq_n_o,
    output logic             fiq_n_o
);

    logic [N_EXT-1:0] sync_w;
    logic [N_EXT-1:0] prev_w;
    logic [N_LOG-1:0] pend_w;
    logic [N_LOG-1:0] en_w;
    logic [N_LOG-1:0] edge_w;

    irqmap_sync #(.N_EXT(N_EXT)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .ext_i  (ext_i),
        .sync_o (sync_w),
        .prev_o (prev_w)
    );

    for (genvar i = 0; i < N_LOG; i++) begin : g_entry
        logic wr_sel;
        // Address decode of the control-word write for this entry.
        assign wr_sel = cfg_we_i && (cfg_idx_i == IDX_W'(i));

        irqmap_entry #(.N_EXT(N_EXT), .SRC_W(SRC_W)) u_entry (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .wr_i    (wr_sel),
            .wdata_i (cfg_wdata_i),
            .clr_i   (clr_we_i && clr_mask_i[i]),
            .sync_i  (sync_w),
            .prev_i  (prev_w),
            .pend_o  (pend_w[i]),
            .en_o    (en_w[i]),
            .edge_o  (edge_w[i])
        );
    end

    irqmap_chan #(.N(N_NORM)) u_norm (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .pend_i  (pend_w[N_NORM-1:0]),
        .en_i    (en_w[N_NORM-1:0]),
        .req_n_o (irq_n_o)
    );

    irqmap_chan #(.N(N_FAST)) u_fast (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .pend_i  (pend_w[N_LOG-1:N_NORM]),
        .en_i    (en_w[N_LOG-1:N_NORM]),
        .req_n_o (fiq_n_o)
    );

    assign pend_o = pend_w;

endmodule

// File: rtl/irqmap_chk.sv
// irqmap_chk: temporal checks on irqmap_top, attached by bind.
// Assumes the enable and edge-mode vectors come from the entry instances.
module irqmap_chk #(
    parameter int N_NORM = 20,
    parameter int N_FAST = 4,
    parameter int IDX_W  = 5,
    localparam int N_LOG = N_NORM + N_FAST
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [IDX_W-1:0] cfg_idx,
    input logic             clr_we,
    input logic [N_LOG-1:0] clr_mask,
    input logic [N_LOG-1:0] pend,
    input logic [N_LOG-1:0] en_vec,
    input logic [N_LOG-1:0] edge_vec,
    input logic             irq_n,
    input logic             fiq_n
);

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (irq_n && fiq_n)); // R1

    AST_NORM_OR: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (irq_n == !$past(|(pend[N_NORM-1:0] & en_vec[N_NORM-1:0])))); // R8

    AST_FAST_OR: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (fiq_n == !$past(|(pend[N_LOG-1:N_NORM] & en_vec[N_LOG-1:N_NORM])))); // R9

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(en_vec[N_NORM-1:0] == '0)) |-> irq_n); // R7

    for (genvar i = 0; i < N_LOG; i++) begin : g_hold
        AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && edge_vec[i] && $past(edge_vec[i]) && $fell(pend[i]))
            |-> ($past(clr_we && clr_mask[i]) || $past(cfg_we && (cfg_idx == IDX_W'(i))))); // R4
    end

endmodule

bind irqmap_top irqmap_chk #(.N_NORM(N_NORM), .N_FAST(N_FAST), .IDX_W(IDX_W)) u_chk (
    .clk      (clk_i),
    .rst_n    (rst_ni),
    .cfg_we   (cfg_we_i),
    .cfg_idx  (cfg_idx_i),
    .clr_we   (clr_we_i),
    .clr_mask (clr_mask_i),
    .pend     (pend_o),
    .en_vec   (en_w),
    .edge_vec (edge_w),
    .irq_n    (irq_n_o),
    .fiq_n    (fiq_n_o)
);

// File: tb/test_irqmap_top.sv
// Scoreboard bench: stimulus tasks queue expected values and a monitor
// compares them against the outputs 1 ns after each falling clock edge.
module test_irqmap_top;

    localparam int N_LOG = 24;

    typedef struct {
        string       req;
        int          kind;   // 0 pend_o, 1 irq_n_o, 2 fiq_n_o
        logic [31:0] exp;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [15:0]       ext = '0;
    logic              cfg_we = 1'b0;
    logic [4:0]        cfg_idx = '0;
    logic [6:0]        cfg_wdata = '0;
    logic              clr_we = 1'b0;
    logic [N_LOG-1:0]  clr_mask = '0;
    logic [N_LOG-1:0]  pend;
    logic              irq_n;
    logic              fiq_n;

    int   n_run = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    exp_t q[$];

    always #2 clk = ~clk;

    irqmap_top i_irqmap_top (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .ext_i       (ext),
        .cfg_we_i    (cfg_we),
        .cfg_idx_i   (cfg_idx),
        .cfg_wdata_i (cfg_wdata),
        .clr_we_i    (clr_we),
        .clr_mask_i  (clr_mask),
        .pend_o      (pend),
        .irq_n_o     (irq_n),
        .fiq_n_o     (fiq_n)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_item(input string r, input int k, input logic [31:0] v);
        exp_t e;
        e.req = r; e.kind = k; e.exp = v;
        q.push_back(e);
    endtask

    task automatic cfg(input int idx, input logic [6:0] d);
        cfg_we = 1'b1; cfg_idx = 5'(idx); cfg_wdata = d;
        tick(1);
        cfg_we = 1'b0;
    endtask

    task automatic clr(input logic [N_LOG-1:0] m);
        clr_we = 1'b1; clr_mask = m;
        tick(1);
        clr_we = 1'b0; clr_mask = '0;
    endtask

    // Monitor: pop and compare everything queued for this sample point.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0) begin
                exp_t e;
                logic [31:0] act;
                e = q.pop_front();
                case (e.kind)
                    0:       act = 32'(pend);
                    1:       act = 32'(irq_n);
                    default: act = 32'(fiq_n);
                endcase
                n_run++;
                if (act !== e.exp) begin
                    n_fail++;
                    $display("FAIL %s kind=%0d actual=%h expected=%h", e.req, e.kind, act, e.exp);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        expect_item("R1", 0, 32'h0); expect_item("R1", 1, 1); expect_item("R1", 2, 1);

        // R2/R3 level, active high, entry 0 on line 3
        ext[3] = 1'b1;
        cfg(0, 7'h43);
        tick(1);
        expect_item("R3", 0, 32'h1); expect_item("R8", 1, 1);
        tick(1);
        expect_item("R8", 1, 0); expect_item("R9", 2, 1);
        ext[3] = 1'b0;
        tick(2);
        expect_item("R3", 0, 32'h0);
        tick(1);
        expect_item("R8", 1, 1);

        // R4 rising edge, entry 1 on line 5, one-cycle pulse
        cfg(1, 7'h55);
        ext[5] = 1'b1;
        tick(1);
        ext[5] = 1'b0;
        tick(1);
        expect_item("R4", 0, 32'h0);
        tick(1);
        expect_item("R4", 0, 32'h2);
        tick(3);
        expect_item("R4", 0, 32'h2); expect_item("R8", 1, 0);

        // R4 falling edge, entry 2 on line 5 inverted
        cfg(2, 7'h75);
        clr(24'h2);
        expect_item("R5", 0, 32'h0);
        ext[5] = 1'b1;
        tick(3);
        expect_item("R4", 0, 32'h2);
        ext[5] = 1'b0;
        tick(3);
        expect_item("R4", 0, 32'h6);
        clr(24'h2);
        expect_item("R5", 0, 32'h4);
        tick(1);
        expect_item("R5", 1, 0);
        clr(24'h4);
        tick(1);
        expect_item("R5", 1, 1);

        // R7 disabled level entry 3 on line 7
        cfg(3, 7'h07);
        ext[7] = 1'b1;
        tick(2);
        expect_item("R7", 0, 32'h8);
        tick(2);
        expect_item("R7", 1, 1); expect_item("R7", 2, 1);

        // R9 fast entry 20 on line 7
        cfg(20, 7'h47);
        expect_item("R9", 0, 32'h100008);
        tick(1);
        expect_item("R9", 2, 0); expect_item("R9", 1, 1);

        // R10 shared input, then remap entry 20 to line 9
        cfg(21, 7'h47);
        expect_item("R10", 0, 32'h300008);
        cfg(20, 7'h49);
        expect_item("R10", 0, 32'h200008);
        tick(1);
        expect_item("R10", 2, 0);
        ext[7] = 1'b0;
        ext[9] = 1'b1;
        tick(2);
        expect_item("R10", 0, 32'h100000);

        // R6 rewriting a control word clears its latch
        ext[5] = 1'b1;
        tick(3);
        expect_item("R6", 0, 32'h100002);
        ext[5] = 1'b0;
        cfg(1, 7'h55);
        expect_item("R6", 0, 32'h100000);
        tick(2);
        expect_item("R4", 0, 32'h100004);

        // R11 out-of-range writes
        cfg(24, 7'h7f);
        cfg(31, 7'h40);
        expect_item("R11", 0, 32'h100004);
        tick(1);
        expect_item("R11", 1, 0); expect_item("R11", 2, 0);

        tick(2);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule